// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block predicts the destination of taken branches for an instruction fetch unit that fetches aligned 16-byte blocks. A lookup presents a fetch address. The low four bits give the byte position of the current instruction inside the block. The middle bits pick one of the sets, and the bits above them form the tag. One cycle later the block reports whether a usable entry exists, with the predicted target and a small branch-kind code for that entry. One fetch block may hold several branches, so every entry records the byte position of its branch. When more than one way matches, the entry chosen is the nearest branch at or after the current instruction.

Resolved taken branches are written through an update port. An entry that matches both tag and byte position is rewritten in place. Otherwise a free way receives the branch, and when the set is full a three-bit tree pseudo-LRU picks the victim. A separate port drops every way of one set, for use when the fetch unit finds that a predicted branch does not exist.

Top module: `fetch_btb`

## Requirements
- R1: After synchronous reset, `rsp_valid` is 0 and every lookup misses until an update has written the addressed set.
- R2: A lookup request in cycle N produces `rsp_valid`=1 with hit, target and kind in cycle N+1. In a cycle that follows no request, `rsp_valid` is 0.
- R3: A way hits only if it is valid, belongs to set `ip[4+SET_W-1:4]`, and holds a tag equal to `ip[4+SET_W+TAG_W-1:4+SET_W]`.
- R4: Among hitting ways, the one selected has the smallest stored byte position that is not below the lookup's `ip[3:0]`. If no stored position qualifies, the result is a miss.
- R5: Address bits above the tag field take no part in any compare, so addresses that differ only there alias.
- R6: An update whose set, tag and byte position match a valid way rewrites that way's target and kind, and no other way is allocated.
- R7: An update with no matching way writes the lowest-numbered invalid way of the set.
- R8: When all four ways are valid, a new branch replaces the tree pseudo-LRU victim. Writing way w turns the tree away from w: root bit = 1 if w<2, else 0; for w<2, left bit = 1 if w==0; for w>=2, right bit = 1 if w==2. The victim is {1,right} if root=1, else {0,left}.
- R9: An invalidate clears every way of the addressed set and resets that set's replacement tree. Other sets keep their entries.
- R10: When an invalidate and an update address the same set in the same cycle, the invalidate wins and the update is dropped.
- R11: The target and kind returned on a hit come from the selected way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_ip | input | IP_W | Lookup fetch address, low 4 bits = current byte position |
| up_valid | input | 1 | Write a resolved taken branch |
| up_ip | input | IP_W | Address of the branch instruction |
| up_target | input | TGT_W | Branch destination |
| up_kind | input | KIND_W | Branch kind code |
| inv_valid | input | 1 | Invalidate a whole set |
| inv_ip | input | IP_W | Address whose set is invalidated |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | A way qualified |
| rsp_target | output | TGT_W | Predicted destination |
| rsp_kind | output | KIND_W | Kind code of the selected entry |

## Verification
The bench builds the block with `SET_W`=3, which leaves the default 9-bit tag and 32-bit target. The tag then sits at `ip[15:7]`. Setting bit 16 therefore reaches the aliasing case, and eight small sets let the bench fill a set, force three pseudo-LRU evictions and spot a wrong victim within a few dozen cycles. The same setting keeps the multi-hit rule, the in-place rewrite and the invalidate-over-update conflict in one compact address range.

// File: rtl/fetch_btb_pkg.sv
package fetch_btb_pkg;
  localparam int WAYS   = 4;
  localparam int WAY_W  = 2;
  localparam int TREE_W = 3;
  localparam int OFF_W  = 4;
  typedef logic [WAY_W-1:0]  way_t;
  typedef logic [TREE_W-1:0] tree_t;
endpackage

// File: rtl/fetch_btb_plru.sv
module fetch_btb_plru
  import fetch_btb_pkg::*;
(
  input  tree_t state,
  input  way_t  touch,
  output tree_t next,
  output way_t  victim
);
  // bit0 = root (1: right pair is older), bit1 = left pair, bit2 = right pair
  always_comb begin
    victim = state[0] ? {1'b1, state[2]} : {1'b0, state[1]};
    next   = state;
    if (!touch[1]) begin
      next[0] = 1'b1;
      next[1] = ~touch[0];
    end else begin
      next[0] = 1'b0;
      next[2] = ~touch[0];
    end
  end
endmodule

// File: rtl/fetch_btb_pick.sv
module fetch_btb_pick
  import fetch_btb_pkg::*;
#(
  parameter int TAG_W = 9
) (
  input  logic [WAYS-1:0]        valid,
  input  logic [TAG_W+OFF_W-1:0] meta [WAYS],
  input  logic [TAG_W-1:0]       tag,
  input  logic [OFF_W-1:0]       cur_off,
  output logic                   hit,
  output way_t                   way
);
  logic [OFF_W-1:0] best;

  always_comb begin
    hit  = 1'b0;
    way  = '0;
    best = '1;
    for (int w = 0; w < WAYS; w++) begin
      if (valid[w] && meta[w][TAG_W+OFF_W-1:OFF_W] == tag &&
          meta[w][OFF_W-1:0] >= cur_off &&
          (!hit || meta[w][OFF_W-1:0] < best)) begin
        hit  = 1'b1;
        way  = way_t'(w);
        best = meta[w][OFF_W-1:0];
      end
    end
  end
endmodule

// File: rtl/fetch_btb.sv
module fetch_btb
  import fetch_btb_pkg::*;
#(
  parameter int IP_W   = 32,
  parameter int SET_W  = 9,
  parameter int TAG_W  = 9,
  parameter int TGT_W  = 32,
  parameter int KIND_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [IP_W-1:0]   lk_ip,
  input  logic              up_valid,
  input  logic [IP_W-1:0]   up_ip,
  input  logic [TGT_W-1:0]  up_target,
  input  logic [KIND_W-1:0] up_kind,
  input  logic              inv_valid,
  input  logic [IP_W-1:0]   inv_ip,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [TGT_W-1:0]  rsp_target,
  output logic [KIND_W-1:0] rsp_kind
);
  localparam int SETS   = 1 << SET_W;
  localparam int TAG_LO = OFF_W + SET_W;
  localparam int TAG_HI = TAG_LO + TAG_W - 1;
  localparam int META_W = TAG_W + OFF_W;
  localparam int DATA_W = TGT_W + KIND_W;

  logic [SET_W-1:0] lk_idx, up_idx, inv_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  assign lk_idx  = lk_ip[TAG_LO-1:OFF_W];
  assign up_idx  = up_ip[TAG_LO-1:OFF_W];
  assign inv_idx = inv_ip[TAG_LO-1:OFF_W];
  assign lk_tag  = lk_ip[TAG_HI:TAG_LO];
  assign up_tag  = up_ip[TAG_HI:TAG_LO];

  // address bits above the tag never take part in a compare
  logic unused_hi;
  assign unused_hi = ^{lk_ip[IP_W-1:TAG_HI+1], up_ip[IP_W-1:TAG_HI+1],
                       inv_ip[IP_W-1:TAG_LO], inv_ip[OFF_W-1:0]};

  logic [WAYS-1:0]  valid_q [SETS];
  tree_t            tree_q  [SETS];
  logic [META_W-1:0] meta_rd [WAYS];
  logic [DATA_W-1:0] data_rd [WAYS];
  logic [META_W-1:0] up_meta [WAYS];
  logic [WAYS-1:0]  we;
  way_t             up_way, victim;
  tree_t            tree_nxt;
  logic             up_go;

  // per-way storage, one synchronous read port for lookup
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [META_W-1:0] meta_mem [SETS];
    logic [DATA_W-1:0] data_mem [SETS];
    logic [META_W-1:0] meta_q;
    logic [DATA_W-1:0] data_q;
    always_ff @(posedge clk) begin
      if (we[w]) begin
        meta_mem[up_idx] <= {up_tag, up_ip[OFF_W-1:0]};
        data_mem[up_idx] <= {up_target, up_kind};
      end
      if (lk_valid) begin
        meta_q <= meta_mem[lk_idx];
        data_q <= data_mem[lk_idx];
      end
    end
    assign up_meta[w] = meta_mem[up_idx];
    assign meta_rd[w] = meta_q;
    assign data_rd[w] = data_q;
  end

  fetch_btb_plru i_plru (
    .state  (tree_q[up_idx]),
    .touch  (up_way),
    .next   (tree_nxt),
    .victim (victim)
  );

  // way choice: matching entry, else lowest free way, else tree victim
  always_comb begin
    logic found, free;
    way_t mway, fway;
    found = 1'b0; free = 1'b0; mway = '0; fway = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (valid_q[up_idx][w] && up_meta[w] == {up_tag, up_ip[OFF_W-1:0]}) begin
        found = 1'b1;
        mway  = way_t'(w);
      end
      if (!valid_q[up_idx][w]) begin
        free = 1'b1;
        fway = way_t'(w);
      end
    end
    up_way = found ? mway : (free ? fway : victim);
    up_go  = up_valid && !(inv_valid && inv_idx == up_idx);
    for (int w = 0; w < WAYS; w++) we[w] = up_go && (up_way == way_t'(w));
  end

  logic [WAYS-1:0]  vld_rd_q;
  logic [TAG_W-1:0] tag_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        tree_q[s]  <= '0;
      end
      rsp_valid <= 1'b0;
      vld_rd_q  <= '0;
      tag_q     <= '0;
      off_q     <= '0;
    end else begin
      if (inv_valid) begin
        valid_q[inv_idx] <= '0;
        tree_q[inv_idx]  <= '0;
      end
      if (up_go) begin
        valid_q[up_idx][up_way] <= 1'b1;
        tree_q[up_idx]          <= tree_nxt;
      end
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        vld_rd_q <= valid_q[lk_idx];
        tag_q    <= lk_tag;
        off_q    <= lk_ip[OFF_W-1:0];
      end
    end
  end

  logic sel_hit;
  way_t sel_way;

  fetch_btb_pick #(.TAG_W(TAG_W)) i_pick (
    .valid   (vld_rd_q),
    .meta    (meta_rd),
    .tag     (tag_q),
    .cur_off (off_q),
    .hit     (sel_hit),
    .way     (sel_way)
  );

  assign rsp_hit    = rsp_valid && sel_hit;
  assign rsp_target = data_rd[sel_way][DATA_W-1:KIND_W];
  assign rsp_kind   = data_rd[sel_way][KIND_W-1:0];

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid); // R2
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid); // R2
  AST_HIT_OFFSET_ORDER: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> meta_rd[sel_way][OFF_W-1:0] >= off_q); // R4
  AST_INV_THEN_MISS: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && $past(inv_valid) && $past(inv_idx) == lk_idx) |=> !rsp_hit); // R9
  AST_INV_BEATS_UPDATE: assert property (@(posedge clk) disable iff (rst)
    (up_valid && inv_valid && up_idx == inv_idx) |=> valid_q[$past(up_idx)] == '0); // R10
endmodule

// File: tb/test_fetch_btb.sv
`timescale 1ns/1ps
module test_fetch_btb;
  localparam int SET_W = 3;
  logic clk = 1'b0, rst = 1'b1;
  logic lk_valid = 0, up_valid = 0, inv_valid = 0;
  logic [31:0] lk_ip = 0, up_ip = 0, inv_ip = 0, up_target = 0;
  logic [1:0]  up_kind = 0;
  logic rsp_valid, rsp_hit;
  logic [31:0] rsp_target;
  logic [1:0]  rsp_kind;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  fetch_btb #(.SET_W(SET_W)) i_fetch_btb (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ip(lk_ip),
    .up_valid(up_valid), .up_ip(up_ip), .up_target(up_target), .up_kind(up_kind),
    .inv_valid(inv_valid), .inv_ip(inv_ip), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_target(rsp_target), .rsp_kind(rsp_kind));

  // address = tag<<7 | set<<4 | byte position (tag field is ip[15:7])
  typedef struct packed {
    logic [1:0]  op;    // 0 update, 1 lookup, 2 invalidate
    logic [31:0] ip;
    logic [31:0] tgt;
    logic [1:0]  kind;
    logic        ehit;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 32'h000000A8, 32'h00001000, 2'd1, 1'b0, 8'd7},  // R7 set2 pos8
    '{2'd0, 32'h000000A3, 32'h00002000, 2'd2, 1'b0, 8'd7},  // R7 set2 pos3
    '{2'd1, 32'h000000A0, 32'h00002000, 2'd2, 1'b1, 8'd4},  // R4 nearest at/after 0
    '{2'd1, 32'h000000A4, 32'h00001000, 2'd1, 1'b1, 8'd11}, // R11 skips pos3
    '{2'd1, 32'h000000A8, 32'h00001000, 2'd1, 1'b1, 8'd4},  // R4 equal position
    '{2'd1, 32'h000000A9, 32'h00000000, 2'd0, 1'b0, 8'd4},  // R4 all below
    '{2'd1, 32'h000100A3, 32'h00002000, 2'd2, 1'b1, 8'd5},  // R5 bit16 aliases
    '{2'd1, 32'h00000120, 32'h00000000, 2'd0, 1'b0, 8'd3},  // R3 other tag
    '{2'd1, 32'h000000B0, 32'h00000000, 2'd0, 1'b0, 8'd3},  // R3 other set
    '{2'd0, 32'h000000A8, 32'h00003000, 2'd3, 1'b0, 8'd6},  // R6 rewrite
    '{2'd1, 32'h000000A4, 32'h00003000, 2'd3, 1'b1, 8'd6},  // R6 new data seen
    '{2'd2, 32'h000000A0, 32'h00000000, 2'd0, 1'b0, 8'd9},  // R9 drop set2
    '{2'd1, 32'h000000A3, 32'h00000000, 2'd0, 1'b0, 8'd9}   // R9 set2 empty
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_up(input logic [31:0] ip, input logic [31:0] tgt, input logic [1:0] k);
    @(negedge clk);
    up_valid = 1; up_ip = ip; up_target = tgt; up_kind = k;
    @(negedge clk);
    up_valid = 0;
  endtask

  task automatic do_inv(input logic [31:0] ip);
    @(negedge clk);
    inv_valid = 1; inv_ip = ip;
    @(negedge clk);
    inv_valid = 0;
  endtask

  task automatic do_lk(input logic [31:0] ip, input logic ehit, input logic [31:0] tgt,
                       input logic [1:0] k, input string req);
    @(negedge clk);
    lk_valid = 1; lk_ip = ip;
    @(negedge clk);
    lk_valid = 0;
    chk(rsp_valid === 1'b1, req, "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(rsp_hit === ehit, req, "hit", 64'(rsp_hit), 64'(ehit));
    if (ehit) begin
      chk(rsp_target === tgt, req, "target", 64'(rsp_target), 64'(tgt));
      chk(rsp_kind === k, req, "kind", 64'(rsp_kind), 64'(k));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(rsp_valid === 1'b0, "R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst = 0;
    do_lk(32'h000000A8, 1'b0, 0, 0, "R1");
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R2", "idle rsp_valid", 64'(rsp_valid), 64'd0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: do_up(VEC[i].ip, VEC[i].tgt, VEC[i].kind);
        2'd1: do_lk(VEC[i].ip, VEC[i].ehit, VEC[i].tgt, VEC[i].kind,
                    $sformatf("R%0d", VEC[i].req));
        default: do_inv(VEC[i].ip);
      endcase
    end

    // R7/R8: fill set 5 with tags 1..4, then three more branches
    do_up(32'h000000D0, 32'hA1, 2'd0);  // A -> way0
    do_up(32'h00000150, 32'hB1, 2'd1);  // B -> way1
    do_up(32'h000001D0, 32'hC1, 2'd2);  // C -> way2
    do_up(32'h00000250, 32'hD1, 2'd3);  // D -> way3
    do_lk(32'h000000D0, 1'b1, 32'hA1, 2'd0, "R7");
    do_lk(32'h00000250, 1'b1, 32'hD1, 2'd3, "R7");
    do_up(32'h000002D0, 32'hE1, 2'd1);  // E replaces A
    do_lk(32'h000000D0, 1'b0, 0, 0, "R8");
    do_lk(32'h000001D0, 1'b1, 32'hC1, 2'd2, "R8");
    do_up(32'h00000350, 32'hF1, 2'd2);  // F replaces C
    do_lk(32'h000001D0, 1'b0, 0, 0, "R8");
    do_up(32'h00000150, 32'hB2, 2'd3);  // rewrite B
    do_up(32'h000003D0, 32'hA7, 2'd0);  // G replaces D
    do_lk(32'h00000250, 1'b0, 0, 0, "R8");
    do_lk(32'h00000150, 1'b1, 32'hB2, 2'd3, "R6");
    do_lk(32'h000002D0, 1'b1, 32'hE1, 2'd1, "R8");
    do_lk(32'h00000350, 1'b1, 32'hF1, 2'd2, "R8");
    do_lk(32'h000003D0, 1'b1, 32'hA7, 2'd0, "R8");

    // R9: invalidate set 1 leaves set 5 intact
    do_up(32'h00000090, 32'h55, 2'd1);
    do_inv(32'h00000090);
    do_lk(32'h00000090, 1'b0, 0, 0, "R9");
    do_lk(32'h00000350, 1'b1, 32'hF1, 2'd2, "R9");

    // R10: same-cycle invalidate and update of set 6
    @(negedge clk);
    up_valid = 1; up_ip = 32'h000000E0; up_target = 32'h66; up_kind = 2'd1;
    inv_valid = 1; inv_ip = 32'h000000E0;
    @(negedge clk);
    up_valid = 0; inv_valid = 0;
    do_lk(32'h000000E0, 1'b0, 0, 0, "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule